// File: doc/BRIEF.md
# Transparent Memory Self-Test Controller

This controller runs a periodic in-field test of a word-organised synchronous RAM and leaves the RAM's contents unchanged. Nothing has to be saved before the session or restored after it. It never compares read data against fixed patterns, because the existing contents are unknown. Instead it first walks the memory with reads only and folds those reads into a predicted signature. During this walk it inverts the words that the later test pass will see in complemented form.

The second walk is the real test. Each element reads a word and writes back its complement. A later sequence complements it again, so every word ends up where it started. This walk folds its read data into a second signature. The two signatures are compared once, and the verdict is held until the next session. A core drives `start_i` while the controller is ready, waits for ready to return, and then samples pass/fail.

The test exposes stuck-at cells, transitions in both directions, and address-decoder faults (ascending and descending orders). It also exposes faults in the read/write paths, through complemented writes and re-reads.

Top module: `tmbist_ctrl`

## Requirements
- R1: Reset state: ready is 1, pass and fail are 0, and the write enable is 0.
- R2: A start seen while ready begins a session, and ready falls in the next cycle. A start seen while a session runs is ignored: the access trace and the session length are unchanged.
- R3: The session first runs a prediction pass of 4 × DEPTH read elements with no write at all. Each element takes 2 cycles, so the pass lasts 8 × DEPTH cycles.
- R4: Both passes run four sequences, numbered 0 to 3, and each sequence visits every address once. Sequences 0 and 1 go from address 0 upwards. Sequences 2 and 3 go from DEPTH-1 downwards. Each element holds its address for both of its cycles.
- R5: In the test pass, an element is a read cycle followed by a write cycle to the same address. The write data is the bitwise complement of the word read in that element.
- R6: After a fault-free session, every RAM word equals its value before the session.
- R7: A fault-free session ends with pass = 1 and fail = 0. Pass and fail are never 1 together.
- R8: A session on a RAM with a stuck-at bit ends with fail = 1 and pass = 0.
- R9: Ready returns exactly 16 × DEPTH + 1 cycles after the start is accepted. That is one cycle after the compare cycle, and the verdict is valid from that cycle.
- R10: While ready and without a new start, pass and fail hold their values.
- R11: The prediction pass inverts the read words in sequences 1 and 3, where the test pass reads complemented data, and leaves sequences 0 and 2 uninverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session request, accepted only while ready |
| ready_o | output | 1 | Idle and able to accept a start |
| pass_o | output | 1 | Last session matched (valid with ready) |
| fail_o | output | 1 | Last session mismatched (valid with ready) |
| mem_addr_o | output | $clog2(DEPTH) | RAM word address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the address |

## Verification
The assertions assume that the RAM returns `mem_rdata_i` exactly one cycle after an address is presented with write enable low. They also assume the RAM reads before it writes, so the word seen in a write cycle is the old value. They assume that `start_i` is a plain level that the controller may ignore while busy. The bench RAM model is registered in exactly that way. The bench changes `start_i` only at falling edges, including one deliberate pulse in the middle of a session. It injects faults only inside the RAM model, never on the controller's pins.

// File: rtl/tmbist_pkg.sv
package tmbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_P_RD  = 3'd1,
    ST_P_CAP = 3'd2,
    ST_T_RD  = 3'd3,
    ST_T_WR  = 3'd4,
    ST_CMP   = 3'd5
  } tmb_state_e;

  localparam int unsigned SEQ_N = 4;
  localparam int unsigned SEQ_W = $clog2(SEQ_N);

  // bit 0 of the sequence index: data read complemented in the test pass
  // bit 1 of the sequence index: descending address order
  function automatic logic seq_inverts(input logic [SEQ_W-1:0] s);
    return s[0];
  endfunction

  function automatic logic seq_descends(input logic [SEQ_W-1:0] s);
    return s[1];
  endfunction

endpackage

// File: rtl/tmbist_addr.sv
module tmbist_addr #(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              desc_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              desc_q, desc_d;
  logic              en;

  assign en = load_i | step_i;

  always_comb begin
    addr_d = addr_q;
    desc_d = desc_q;
    if (load_i) begin
      desc_d = desc_i;
      addr_d = desc_i ? TOP : '0;
    end else if (step_i) begin
      addr_d = desc_q ? (addr_q - 1'b1) : (addr_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      desc_q <= 1'b0;
    end else if (en) begin
      addr_q <= addr_d;
      desc_q <= desc_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = desc_q ? (addr_q == '0) : (addr_q == TOP);

endmodule

// File: rtl/tmbist_misr.sv
module tmbist_misr #(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    POLY = 8'h71
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] sig_o
);

  logic [W-1:0] sig_q, sig_d;

  // internal-XOR parallel compactor, one stage per bit
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign sig_d[i] = (sig_q[W-1] & POLY[i]) ^ din_i[i];
    end else begin : g_body
      assign sig_d[i] = sig_q[i-1] ^ (sig_q[W-1] & POLY[i]) ^ din_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (clr_i) begin
      sig_q <= '0;
    end else if (en_i) begin
      sig_q <= sig_d;
    end
  end

  assign sig_o = sig_q;

endmodule

// File: rtl/tmbist_seq.sv
module tmbist_seq
  import tmbist_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             last_i,
  output tmb_state_e       state_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             addr_load_o,
  output logic             addr_desc_o,
  output logic             addr_step_o,
  output logic             sig_clr_o,
  output logic             cap_pred_o,
  output logic             cap_test_o,
  output logic             verdict_en_o
);

  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_N - 1);

  tmb_state_e       st_q, st_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             seq_en;

  always_comb begin
    st_d         = st_q;
    seq_d        = seq_q;
    seq_en       = 1'b0;
    addr_load_o  = 1'b0;
    addr_desc_o  = 1'b0;
    addr_step_o  = 1'b0;
    sig_clr_o    = 1'b0;
    cap_pred_o   = 1'b0;
    cap_test_o   = 1'b0;
    verdict_en_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d        = ST_P_RD;
          seq_d       = '0;
          seq_en      = 1'b1;
          addr_load_o = 1'b1;
          addr_desc_o = seq_descends('0);
          sig_clr_o   = 1'b1;
        end
      end
      ST_P_RD: st_d = ST_P_CAP;
      ST_P_CAP: begin
        cap_pred_o = 1'b1;
        st_d       = ST_P_RD;
        if (!last_i) begin
          addr_step_o = 1'b1;
        end else begin
          seq_en      = 1'b1;
          addr_load_o = 1'b1;
          if (seq_q == SEQ_LAST) begin
            st_d  = ST_T_RD;
            seq_d = '0;
          end else begin
            seq_d = seq_q + 1'b1;
          end
          addr_desc_o = seq_descends(seq_d);
        end
      end
      ST_T_RD: st_d = ST_T_WR;
      ST_T_WR: begin
        cap_test_o = 1'b1;
        st_d       = ST_T_RD;
        if (!last_i) begin
          addr_step_o = 1'b1;
        end else if (seq_q == SEQ_LAST) begin
          st_d = ST_CMP;
        end else begin
          seq_en      = 1'b1;
          seq_d       = seq_q + 1'b1;
          addr_load_o = 1'b1;
          addr_desc_o = seq_descends(seq_d);
        end
      end
      ST_CMP: begin
        verdict_en_o = 1'b1;
        st_d         = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
    end else if (seq_en) begin
      seq_q <= seq_d;
    end
  end

  assign state_o = st_q;
  assign seq_o   = seq_q;

endmodule

// File: rtl/tmbist_ctrl.sv
module tmbist_ctrl
  import tmbist_pkg::*;
#(
  parameter int unsigned         DEPTH  = 16,
  parameter int unsigned         DATA_W = 8,
  parameter logic [DATA_W-1:0]   POLY   = 8'h71,
  localparam int unsigned        ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              ready_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  tmb_state_e       state;
  logic [SEQ_W-1:0] seq;
  logic             addr_load, addr_desc, addr_step, addr_last;
  logic             sig_clr, cap_pred, cap_test, verdict_en;
  logic [DATA_W-1:0] pred_din, sig_pred, sig_test;
  logic             done_q, done_d, match_q, match_d, res_en;

  tmbist_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .last_i       (addr_last),
    .state_o      (state),
    .seq_o        (seq),
    .addr_load_o  (addr_load),
    .addr_desc_o  (addr_desc),
    .addr_step_o  (addr_step),
    .sig_clr_o    (sig_clr),
    .cap_pred_o   (cap_pred),
    .cap_test_o   (cap_test),
    .verdict_en_o (verdict_en)
  );

  tmbist_addr #(.DEPTH(DEPTH)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (addr_load),
    .desc_i (addr_desc),
    .step_i (addr_step),
    .addr_o (mem_addr_o),
    .last_o (addr_last)
  );

  // prediction reads see original data; complement them where the test pass reads complements
  assign pred_din = mem_rdata_i ^ {DATA_W{seq_inverts(seq)}};

  tmbist_misr #(.W(DATA_W), .POLY(POLY)) u_sig_pred (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (sig_clr),
    .en_i  (cap_pred),
    .din_i (pred_din),
    .sig_o (sig_pred)
  );

  tmbist_misr #(.W(DATA_W), .POLY(POLY)) u_sig_test (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (sig_clr),
    .en_i  (cap_test),
    .din_i (mem_rdata_i),
    .sig_o (sig_test)
  );

  assign mem_we_o    = (state == ST_T_WR);
  assign mem_wdata_o = ~mem_rdata_i;

  assign res_en  = sig_clr | verdict_en;
  assign done_d  = verdict_en;
  assign match_d = verdict_en & (sig_pred == sig_test);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else if (res_en) begin
      done_q  <= done_d;
      match_q <= match_d;
    end
  end

  assign ready_o = (state == ST_IDLE);
  assign pass_o  = ready_o & done_q & match_q;
  assign fail_o  = ready_o & done_q & ~match_q;

endmodule

// File: rtl/tmbist_ctrl_chk.sv
module tmbist_ctrl_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ready_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i
);

  localparam int unsigned SESS = 16 * DEPTH + 1;
  localparam int unsigned CW   = $clog2(SESS + 2) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ready_o && start_i) begin
      cnt_q <= '0;
    end else if (!ready_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> ready_o && !mem_we_o && !pass_o && !fail_o); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) ready_o && start_i |=> !ready_o); // R2
  AST_PRED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !ready_o && (cnt_q < CW'(8 * DEPTH)) |-> !mem_we_o); // R3
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_we_o |-> !$past(mem_we_o) && (mem_addr_o == $past(mem_addr_o))); // R5
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pass_o && fail_o)); // R7
  AST_READY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready_o) |-> cnt_q == CW'(SESS)); // R9
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ready_o && !start_i |=> $stable(pass_o) && $stable(fail_o)); // R10

endmodule

bind tmbist_ctrl tmbist_ctrl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ready_o     (ready_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/sim_tmbist_ctrl.sv
`timescale 1ns/1ps
module sim_tmbist_ctrl;

  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int SESS   = 16 * DEPTH + 1;

  logic              clk, rst_n, start;
  logic              ready, pass, fail, we;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] snap [DEPTH];
  logic              flt_en, flt_val;
  logic [ADDR_W-1:0] flt_addr;
  int                flt_bit;

  int tests, fails;

  tmbist_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ready_o(ready),
    .pass_o(pass), .fail_o(fail), .mem_addr_o(addr), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] stick(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    if (flt_en && a == flt_addr) r[flt_bit] = flt_val;
    return r;
  endfunction

  // registered read-before-write RAM
  always @(posedge clk) begin
    if (we) mem[addr] <= stick(addr, wdata);
    rdata <= mem[addr];
  end

  task automatic check(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_addr(input int c);
    int e, s, idx;
    e = c / 2; s = (e / DEPTH) % 4; idx = e % DEPTH;
    return (s >= 2) ? (DEPTH - 1 - idx) : idx;
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < DEPTH; i++) begin
      logic [DATA_W-1:0] v;
      v = (mode == 0) ? '0 : (mode == 1) ? '1 : DATA_W'($urandom);
      mem[i] = stick(ADDR_W'(i), v);
      snap[i] = mem[i];
    end
  endtask

  task automatic session(input int mid, input bit expect_pass, input string tag);
    int pw, ae, wde, busy;
    pw = 0; ae = 0; wde = 0; busy = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < SESS; c++) begin
      if (c == mid) start = 1'b1;
      if (c == mid + 1) start = 1'b0;
      if (ready) busy++;
      if (c < 8 * DEPTH && we) pw++;
      if (c < 16 * DEPTH) begin
        if (int'(addr) != exp_addr(c)) ae++;
        if (we != (c >= 8 * DEPTH && (c % 2) == 1)) ae++;
        if (we && wdata != ~mem[addr]) wde++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(busy == 0, "R9", {tag, " ready during session"}, busy, 0);
    check(ready == 1'b1, "R9", {tag, " ready after 16*DEPTH+1"}, ready, 1);
    check(pw == 0, "R3", {tag, " writes in prediction pass"}, pw, 0);
    check(ae == 0, "R4", {tag, " address/enable trace"}, ae, 0);
    check(wde == 0, "R5", {tag, " complement write data"}, wde, 0);
    if (mid >= 0) check(ae == 0 && busy == 0, "R2", {tag, " start while busy ignored"}, ae + busy, 0);
    if (expect_pass) begin
      int diff;
      diff = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] != snap[i]) diff++;
      check(diff == 0, "R6", {tag, " contents restored"}, diff, 0);
      check(pass && !fail, "R7", {tag, " fault-free verdict"}, {pass, fail}, 2'b10);
      check(pass && !fail, "R11", {tag, " inverted prediction matches"}, {pass, fail}, 2'b10);
    end else begin
      check(fail && !pass, "R8", {tag, " stuck-at verdict"}, {pass, fail}, 2'b01);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    start = 1'b0; flt_en = 1'b0; flt_val = 1'b0; flt_addr = '0; flt_bit = 0;
    rst_n = 1'b0;
    void'($urandom(32'h5EED));
    fill(2);
    repeat (3) @(negedge clk);
    check(ready && !pass && !fail && !we, "R1", "reset state", {ready, pass, fail, we}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !pass && !fail && !we, "R1", "idle after reset", {ready, pass, fail, we}, 4'b1000);

    session(37, 1'b1, "random+midstart");
    repeat (20) @(negedge clk);
    check(pass && !fail, "R10", "verdict held while idle", {pass, fail}, 2'b10);

    fill(0); session(-1, 1'b1, "all-zero");
    fill(1); session(-1, 1'b1, "all-one");

    flt_en = 1'b1; flt_addr = '0; flt_bit = 3; flt_val = 1'b0;
    fill(2); session(-1, 1'b0, "stuck0@first");
    flt_addr = ADDR_W'(DEPTH - 1); flt_bit = DATA_W - 1; flt_val = 1'b1;
    fill(2); session(-1, 1'b0, "stuck1@last");
    repeat (10) @(negedge clk);
    check(fail && !pass, "R10", "fail held while idle", {pass, fail}, 2'b01);

    for (int k = 0; k < 3; k++) begin
      flt_en = 1'b0; fill(2); session(-1, 1'b1, "random clean");
      flt_en = 1'b1; flt_addr = ADDR_W'($urandom % DEPTH);
      flt_bit = int'($urandom % DATA_W); flt_val = 1'(($urandom) & 1);
      fill(2); session(-1, 1'b0, "random stuck");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule